// File: doc/BRIEF.md
# Keyed Down-Counting Watchdog Timer

This block is a watchdog that software controls through a small word-addressed register bus. A 32-bit counter counts down from a programmed start value. It counts either once per system clock or once per tick of a prescaled timebase of about 1 MHz. Software keeps the system alive by writing a fixed 16-bit key to a dedicated kick register. Only that exact value reloads the counter. Every other value written there is discarded.

When the counter reaches zero while counting is enabled, the block raises a single-cycle expiry event. It then holds the count at zero. Three actions can follow the expiry, and each has its own enable: a fixed-length reset pulse, a level interrupt, and a fixed-length external strobe. Each action can be turned on or off independently. A two-bit scope code travels out with the reset pulse so that the reset logic outside the block can tell a local reset from a whole-device reset.

Registers sit at byte offsets 0x0 (live count, read; interrupt clear, write), 0x4 (start value), 0x8 (kick) and 0xC (control). All of them are zero after reset, so the watchdog starts disabled.

Top module: `wdog_timer`

## Requirements
- R1: After reset, every register reads back as zero and expire_o, irq_o, sys_rst_o, ext_o and rst_scope_o are all low.
- R2: Offset 0x4 reads back the last value written. Offset 0xC reads back bits [6:0] of the last write, with all higher bits zero. Offset 0x8 always reads zero. Offset 0x0 reads the live counter.
- R3: A write of exactly 0x00004755 to offset 0x8 loads the counter from the start value register on the next clock edge.
- R4: A write of any other value to offset 0x8 leaves the counter unchanged.
- R5: With control bit 0 set and bit 4 clear, the counter drops by one on each clock. Expiry is seen exactly N cycles after the enabling write when the start value is N.
- R6: With control bits 0 and 4 both set, the counter drops by one once every TICK_DIV clocks. Expiry from start value N comes between (N-1)*TICK_DIV+1 and N*TICK_DIV cycles after the enabling write.
- R7: At expiry, expire_o is high for exactly one cycle. The counter then stays at zero and raises no further event until it is reloaded or disabled.
- R8: When control bit 1 is set, sys_rst_o goes high on the cycle after expiry and stays high for RST_LEN cycles. rst_scope_o carries control bits [6:5] while sys_rst_o is high and reads zero otherwise.
- R9: When control bit 2 is set, irq_o goes high on the cycle after expiry and stays high until software writes 1 to bit 0 of offset 0x0 or writes a valid key to the kick register.
- R10: When control bit 3 is set, ext_o goes high on the cycle after expiry and stays high for EXT_LEN cycles.
- R11: Clearing control bit 0 freezes the counter at its present value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational on a read access |
| expire_o | output | 1 | Single-cycle expiry event |
| irq_o | output | 1 | Level interrupt |
| sys_rst_o | output | 1 | Reset request pulse |
| rst_scope_o | output | 2 | Reset scope code, valid while sys_rst_o is high |
| ext_o | output | 1 | External strobe pulse |

## Verification
The bench sweeps start values from zero upward in clock mode and measures the expiry latency to the exact cycle. A design with an off-by-one in its zero detect, or one that misses the zero-start case, reports the wrong latency. In the same sweep the action enables and scope codes are cycled, and the width of each pulse is measured. A stretcher with a wrong length, a scope that leaks outside the reset pulse, or a second expiry event from the held-zero counter would each show up in these measurements. Near-miss kick values, disabling in mid-count, and clearing the interrupt by kick are all aimed at designs that compare too few key bits or keep counting when they should not.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   // word index of each register (byte address bits [3:2])
   localparam logic [1:0] IDX_COUNT  = 2'd0;
   localparam logic [1:0] IDX_START  = 2'd1;
   localparam logic [1:0] IDX_KICK   = 2'd2;
   localparam logic [1:0] IDX_CTRL   = 2'd3;

   localparam logic [15:0] KICK_KEY  = 16'h4755;
   localparam int unsigned CTRL_W    = 7;

   // control register, laid out from bit 6 down to bit 0
   typedef struct packed {
      logic [1:0] scope;     // [6:5]
      logic       tick_sel;  // [4]
      logic       ext_en;    // [3]
      logic       irq_en;    // [2]
      logic       rst_en;    // [1]
      logic       run_en;    // [0]
   } wd_ctrl_t;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] cnt_i,
   output logic [DATA_W-1:0] bus_rdata,
   output wd_ctrl_t          ctrl_o,
   output logic [DATA_W-1:0] start_o,
   output logic              kick_ok_o,
   output logic              irq_clr_o
);

   logic       hi_ok;
   logic [1:0] idx;
   logic       wr;
   logic       unused_addr;

   generate
      if (ADDR_W > 4) begin : g_hi
         assign hi_ok = (bus_addr[ADDR_W-1:4] == '0);
      end else begin : g_nohi
         assign hi_ok = 1'b1;
      end
   endgenerate

   assign idx         = bus_addr[3:2];
   assign unused_addr = ^bus_addr[1:0];
   assign wr          = bus_valid && bus_write && hi_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_o  <= '0;
         start_o <= '0;
      end else if (wr) begin
         if (idx == IDX_CTRL)  ctrl_o  <= wd_ctrl_t'(bus_wdata[CTRL_W-1:0]);
         if (idx == IDX_START) start_o <= bus_wdata;
      end
   end

   // the whole data word must match the key, not only its low half
   assign kick_ok_o = wr && (idx == IDX_KICK) &&
                      (bus_wdata == DATA_W'(KICK_KEY));
   assign irq_clr_o = wr && (idx == IDX_COUNT) && bus_wdata[0];

   always_comb begin
      bus_rdata = '0;
      if (bus_valid && !bus_write && hi_ok) begin
         case (idx)
            IDX_COUNT: bus_rdata = cnt_i;
            IDX_START: bus_rdata = start_o;
            IDX_CTRL:  bus_rdata = DATA_W'(ctrl_o);
            default:   bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/wdog_tick.sv
module wdog_tick #(
   parameter int unsigned DIV = 100
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);

   generate
      if (DIV < 1) begin : g_bad
         $error("wdog_tick: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_pass
         assign tick_o = 1'b1;
      end else begin : g_div
         localparam int unsigned TW = $clog2(DIV);
         logic [TW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      div_q <= '0;
            else if (div_q == TW'(DIV - 1)) div_q <= '0;
            else                             div_q <= div_q + 1'b1;
         end
         assign tick_o = (div_q == TW'(DIV - 1));
      end
   endgenerate

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             step,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt_o,
   output logic             expire_o
);

   logic fired_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           cnt_o <= '0;
      else if (load)                        cnt_o <= load_val;
      else if (run_en && step && cnt_o != '0) cnt_o <= cnt_o - 1'b1;
   end

   // remembers that the zero has already been reported
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                fired_q <= 1'b0;
      else if (load || !run_en)  fired_q <= 1'b0;
      else if (expire_o)         fired_q <= 1'b1;
   end

   assign expire_o = run_en && (cnt_o == '0) && !fired_q;

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
   parameter int unsigned LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic pulse_o
);

   localparam int unsigned PW = $clog2(LEN + 1);

   generate
      if (LEN < 1) begin : g_bad
         $error("wdog_pulse: LEN must be at least 1");
      end
   endgenerate

   logic [PW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             left_q <= '0;
      else if (trig)          left_q <= PW'(LEN);
      else if (left_q != '0)  left_q <= left_q - 1'b1;
   end

   assign pulse_o = (left_q != '0);

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
   import wdog_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned TICK_DIV = 100,
   parameter int unsigned RST_LEN  = 16,
   parameter int unsigned EXT_LEN  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              expire_o,
   output logic              irq_o,
   output logic              sys_rst_o,
   output logic [1:0]        rst_scope_o,
   output logic              ext_o
);

   generate
      if (DATA_W < 16 || DATA_W > 32) begin : g_bad_w
         $error("wdog_timer: DATA_W must lie in 16..32");
      end
      if (ADDR_W < 4) begin : g_bad_a
         $error("wdog_timer: ADDR_W must be at least 4");
      end
   endgenerate

   wd_ctrl_t          ctrl;
   logic [DATA_W-1:0] start_val;
   logic [DATA_W-1:0] cnt;
   logic              kick_ok;
   logic              irq_clr;
   logic              tick;
   logic              step;
   logic              irq_q;
   logic [1:0]        scope_q;

   wdog_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_valid (bus_valid),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .cnt_i     (cnt),
      .bus_rdata (bus_rdata),
      .ctrl_o    (ctrl),
      .start_o   (start_val),
      .kick_ok_o (kick_ok),
      .irq_clr_o (irq_clr)
   );

   wdog_tick #(.DIV(TICK_DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   assign step = ctrl.tick_sel ? tick : 1'b1;

   wdog_count #(.CNT_W(DATA_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_en   (ctrl.run_en),
      .step     (step),
      .load     (kick_ok),
      .load_val (start_val),
      .cnt_o    (cnt),
      .expire_o (expire_o)
   );

   wdog_pulse #(.LEN(RST_LEN)) u_rst_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig    (expire_o && ctrl.rst_en),
      .pulse_o (sys_rst_o)
   );

   wdog_pulse #(.LEN(EXT_LEN)) u_ext_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig    (expire_o && ctrl.ext_en),
      .pulse_o (ext_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          scope_q <= '0;
      else if (expire_o && ctrl.rst_en)    scope_q <= ctrl.scope;
   end

   assign rst_scope_o = sys_rst_o ? scope_q : 2'b00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       irq_q <= 1'b0;
      else if (kick_ok || irq_clr)      irq_q <= 1'b0;
      else if (expire_o && ctrl.irq_en) irq_q <= 1'b1;
   end

   assign irq_o = irq_q;

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] cnt,
   input logic [DATA_W-1:0] start_val,
   input logic              run_en,
   input logic              kick_ok,
   input logic              expire_o,
   input logic              irq_o,
   input logic              sys_rst_o,
   input logic [1:0]        rst_scope_o,
   input logic              ext_o
);

   // R3
   kick_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kick_ok |=> cnt == $past(start_val));

   // R4 R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !kick_ok) |=> $stable(cnt));

   // R7
   single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |=> !expire_o);

   // R7
   event_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |-> cnt == '0);

   // R8
   scope_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sys_rst_o |-> rst_scope_o == 2'b00);

   // R8
   rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst_o) |-> $past(expire_o));

   // R9
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(expire_o));

   // R10
   ext_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_o) |-> $past(expire_o));

endmodule

bind wdog_timer wdog_chk #(.DATA_W(DATA_W)) u_wdog_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cnt         (cnt),
   .start_val   (start_val),
   .run_en      (ctrl.run_en),
   .kick_ok     (kick_ok),
   .expire_o    (expire_o),
   .irq_o       (irq_o),
   .sys_rst_o   (sys_rst_o),
   .rst_scope_o (rst_scope_o),
   .ext_o       (ext_o)
);

// File: tb/wdog_timer_bench.sv
`timescale 1ns/1ps
module wdog_timer_bench;

   localparam int DIV  = 4;
   localparam int RLEN = 5;
   localparam int ELEN = 3;
   localparam logic [3:0] A_CNT = 4'h0, A_START = 4'h4, A_KICK = 4'h8, A_CTRL = 4'hC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        expire_o, irq_o, sys_rst_o, ext_o;
   logic [1:0]  rst_scope_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   wdog_timer #(.DATA_W(32), .ADDR_W(4), .TICK_DIV(DIV), .RST_LEN(RLEN), .EXT_LEN(ELEN)) u_wdog_timer (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .expire_o(expire_o), .irq_o(irq_o), .sys_rst_o(sys_rst_o),
      .rst_scope_o(rst_scope_o), .ext_o(ext_o));

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      #0.5;
      d = bus_rdata;
      bus_valid = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   // counts cycles from the enabling write until expire_o is seen
   task automatic wait_expire(output int n);
      n = 0;
      while (!expire_o && n < 2000) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         summary();
      end
   end

   initial begin
      logic [31:0] d;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(4'(a * 4), d);
         check(d == 0, "R1 reg", d, 0);
      end
      check({expire_o, irq_o, sys_rst_o, ext_o, rst_scope_o} == 0, "R1 outputs",
            {expire_o, irq_o, sys_rst_o, ext_o, rst_scope_o}, 0);

      // R2 readback
      wr(A_START, 32'hA5A5_1234);
      rd(A_START, d); check(d == 32'hA5A5_1234, "R2 start", d, 32'hA5A5_1234);
      wr(A_CTRL, 32'h0000_007E);
      rd(A_CTRL, d);  check(d == 32'h7E, "R2 ctrl", d, 32'h7E);
      wr(A_CTRL, 32'hFFFF_FF92);
      rd(A_CTRL, d);  check(d == 32'h12, "R2 ctrl mask", d, 32'h12);
      rd(A_KICK, d);  check(d == 0, "R2 kick reads zero", d, 0);
      wr(A_CTRL, 0);

      // R3 R4 key handling
      wr(A_START, 37);
      wr(A_KICK, 32'h0000_4754);
      rd(A_CNT, d); check(d == 0, "R4 near key", d, 0);
      wr(A_KICK, 32'h0001_4755);
      rd(A_CNT, d); check(d == 0, "R4 upper bits", d, 0);
      wr(A_KICK, 32'h0000_4755);
      rd(A_CNT, d); check(d == 37, "R3 kick loads", d, 37);
      wr(A_START, 90);
      wr(A_KICK, 32'h0000_B8AA);
      rd(A_CNT, d); check(d == 37, "R4 ignored after load", d, 37);

      // R5 R7 R8 R9 R10 sweep in clock mode
      for (int r = 0; r <= 10; r++) begin
         int act, sc, rc, ec, xc, bad_sc;
         act = r % 8;
         sc  = r % 4;
         wr(A_CTRL, 0);
         wr(A_START, r);
         wr(A_KICK, 32'h4755);
         wr(A_CTRL, 32'(1 | (act << 1) | (sc << 5)));
         wait_expire(n);
         check(n == r, "R5 latency", n, r);
         rc = 0; ec = 0; xc = 0; bad_sc = 0;
         for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            if (expire_o) xc++;
            if (sys_rst_o) begin
               rc++;
               if (rst_scope_o != 2'(sc)) bad_sc++;
            end else if (rst_scope_o != 0) bad_sc++;
            if (ext_o) ec++;
            if (j == 0) check(irq_o == act[1], "R9 irq set", irq_o, act[1]);
         end
         check(xc == 0, "R7 single event", xc, 0);
         check(rc == (act[0] ? RLEN : 0), "R8 reset width", rc, act[0] ? RLEN : 0);
         check(bad_sc == 0, "R8 scope", bad_sc, 0);
         check(ec == (act[2] ? ELEN : 0), "R10 ext width", ec, act[2] ? ELEN : 0);
         rd(A_CNT, d); check(d == 0, "R7 held zero", d, 0);
         check(irq_o == act[1], "R9 irq holds", irq_o, act[1]);
         wr(A_CNT, 1);
         check(irq_o == 0, "R9 cleared by status write", irq_o, 0);
      end

      // R6 tick mode
      for (int r = 1; r <= 4; r++) begin
         wr(A_CTRL, 0);
         wr(A_START, r);
         wr(A_KICK, 32'h4755);
         wr(A_CTRL, 32'h11);
         wait_expire(n);
         check(n >= (r - 1) * DIV + 1 && n <= r * DIV, "R6 tick latency", n, r * DIV);
      end

      // R11 freeze on disable
      wr(A_CTRL, 0);
      wr(A_START, 1000);
      wr(A_KICK, 32'h4755);
      wr(A_CTRL, 1);
      repeat (20) @(negedge clk);
      wr(A_CTRL, 0);
      rd(A_CNT, d);
      check(d < 1000 && d > 900, "R11 counted", d, 979);
      n = int'(d);
      repeat (30) @(negedge clk);
      rd(A_CNT, d); check(d == 32'(n), "R11 frozen", d, n);

      // R9 cleared by valid kick
      wr(A_START, 2);
      wr(A_KICK, 32'h4755);
      wr(A_CTRL, 32'h5);
      wait_expire(n);
      @(negedge clk);
      check(irq_o == 1, "R9 irq before kick", irq_o, 1);
      wr(A_KICK, 32'h4755);
      check(irq_o == 0, "R9 cleared by kick", irq_o, 0);
      rd(A_CNT, d); check(d == 2 || d == 1, "R3 reload on kick", d, 2);

      done = 1'b1;
      summary();
   end

endmodule